// File: doc/BRIEF.md
# Flash Converter Thermometer-to-Binary Encoder

This block sits behind the comparator bank of an 8-bit flash converter. It takes the 255 comparator decisions, which form a thermometer word, and returns the number of comparators that read zero as an 8-bit binary code. The code is captured in an output register on the sample clock.

Each comparator bit is combined with the bit just below it. The result is a one-cold bus in which one zero marks the thermometer edge. That bus is extended to 256 bits and cut into 16 slices of 16 bits. One small locator per slice reports where its zero sits, and the 16 slice results are merged by a bitwise OR into the low nibble. A seventeenth locator works on the per-slice activity flags and yields the high nibble. The block has no state machine. Its only storage is the output code register.

Top module: `flash_therm_encoder`

The register has two named behaviours. The first is reset: an active-high synchronous reset loads zero. The second is capture: on every other rising edge the register loads the merged code.

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `code_o` becomes 0 at that edge, whatever `cmp_i` holds.
- R2: Outside reset, `code_o` takes the code of the `cmp_i` value present at a rising edge of `clk`, right after that edge. This gives one cycle of latency.
- R3: For a valid thermometer input, `code_o` equals k, the number of comparators that read 0. In a valid thermometer input, bits 0 to k-1 of `cmp_i` are 0 and bits k to 254 are 1. Bit 0 is the lowest comparator.
- R4: An all-ones `cmp_i` (input below the lowest threshold) encodes as 8'h00.
- R5: An all-zeros `cmp_i` (input above the highest threshold) encodes as 8'hFF.
- R6: Edges that fall on a 16-bit slice boundary encode correctly: k = 15, 16, 17, 31, 32, 128, 239, 240 and 254.
- R7: If a bubble leaves several zeros on the one-cold bus, `code_o` is the bitwise OR of the bus positions of those zeros. Bus position p is zero when `cmp_i[p]` is 1 and `cmp_i[p-1]` is 0. Below bit 0, the comparator input is taken as 0; above bit 254, it is taken as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 255 | Comparator decisions, bit 0 lowest threshold |
| code_o | output | 8 | Registered binary code |

## Verification
The main function is tried with all 256 legal thermometer words. This sweep distinguishes every bus position, so a wrong slice index, a swapped nibble or a broken OR term each show up at a specific code. A short table of slice-boundary edges repeats the points where a zero moves from one locator to the next. The two end words confirm the role of the constant padding at each end. A two-zero bubble word separates a true OR merge from a priority pick. A reset applied while the inputs ask for full scale shows that reset takes precedence over capture.

// File: rtl/fte_pkg.sv
package fte_pkg;
    localparam int SLICE_W_DEF   = 16;
    localparam int SLICE_CNT_DEF = 16;

    // Mask of slice positions whose index has bit b set
    function automatic logic [63:0] pos_mask(input int width, input int b);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < width; i++) begin
            m[i] = i[b];
        end
        return m;
    endfunction
endpackage

// File: rtl/fte_onecold.sv
module fte_onecold #(
    parameter int N_CMP = 255
) (
    input  logic [N_CMP-1:0] cmp_i,
    output logic [N_CMP:0]   bus_n_o
);
    // Position p is zero when the comparator at p reads 1 and the one below reads 0.
    // Below the bottom the comparator is taken as 0; above the top it is taken as 1.
    for (genvar p = 0; p <= N_CMP; p++) begin : g_pos
        logic lower, upper;
        if (p == 0) begin : g_bot
            assign lower = 1'b0;
        end else begin : g_mid_lo
            assign lower = cmp_i[p-1];
        end
        if (p == N_CMP) begin : g_top
            assign upper = 1'b1;
        end else begin : g_mid_hi
            assign upper = cmp_i[p];
        end
        assign bus_n_o[p] = ~(upper & ~lower);
    end
endmodule

// File: rtl/fte_zero_locator.sv
module fte_zero_locator #(
    parameter int W  = 16,
    localparam int LW = $clog2(W)
) (
    input  logic [W-1:0]  bus_n_i,
    output logic [LW-1:0] pos_o,
    output logic          hit_o
);
    import fte_pkg::*;

    logic [W-1:0] zeros;
    assign zeros = ~bus_n_i;
    assign hit_o = |zeros;

    for (genvar b = 0; b < LW; b++) begin : g_bit
        localparam logic [63:0] MASK = pos_mask(W, b);
        assign pos_o[b] = |(zeros & MASK[W-1:0]);
    end
endmodule

// File: rtl/fte_code_reg.sv
module fte_code_reg #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_d,
    output logic [CODE_W-1:0] code_q
);
    typedef enum logic {REG_RESET, REG_CAPTURE} reg_mode_e;
    reg_mode_e mode;

    always_comb begin
        mode = rst ? REG_RESET : REG_CAPTURE;
    end

    always_ff @(posedge clk) begin
        unique case (mode)
            REG_RESET:   code_q <= '0;
            REG_CAPTURE: code_q <= code_d;
            default:     code_q <= '0;
        endcase
    end

    // R1: a reset edge leaves the register cleared
    logic rst_seen_q = 1'b0;
    always_ff @(posedge clk) rst_seen_q <= rst;
    always @(negedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clears_R1: assert (code_q == '0);
        end
    end
endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder #(
    parameter int SLICE_W   = fte_pkg::SLICE_W_DEF,
    parameter int SLICE_CNT = fte_pkg::SLICE_CNT_DEF,
    localparam int N_CMP  = SLICE_W * SLICE_CNT - 1,
    localparam int LO_W   = $clog2(SLICE_W),
    localparam int HI_W   = $clog2(SLICE_CNT),
    localparam int CODE_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CMP-1:0]  cmp_i,
    output logic [CODE_W-1:0] code_o
);
    logic [N_CMP:0]   bus_n;
    logic [LO_W-1:0]  slice_pos [SLICE_CNT];
    logic [SLICE_CNT-1:0] slice_hit;
    logic [LO_W-1:0]  lo_code;
    logic [HI_W-1:0]  hi_code;
    logic             hi_hit;

    fte_onecold #(.N_CMP(N_CMP)) u_onecold (
        .cmp_i   (cmp_i),
        .bus_n_o (bus_n)
    );

    for (genvar s = 0; s < SLICE_CNT; s++) begin : g_slice
        fte_zero_locator #(.W(SLICE_W)) u_loc (
            .bus_n_i (bus_n[s*SLICE_W +: SLICE_W]),
            .pos_o   (slice_pos[s]),
            .hit_o   (slice_hit[s])
        );
    end

    // Only one slice holds the zero on a clean input, so OR merges safely
    always_comb begin
        lo_code = '0;
        for (int s = 0; s < SLICE_CNT; s++) begin
            lo_code = lo_code | slice_pos[s];
        end
    end

    fte_zero_locator #(.W(SLICE_CNT)) u_slice_index (
        .bus_n_i (~slice_hit),
        .pos_o   (hi_code),
        .hit_o   (hi_hit)
    );

    fte_code_reg #(.CODE_W(CODE_W)) u_code_reg (
        .clk    (clk),
        .rst    (rst),
        .code_d ({hi_code, lo_code}),
        .code_q (code_o)
    );

    // Thermometer check: no comparator reads 1 with a 0 above it
    logic therm_ok;
    assign therm_ok = ~|(cmp_i[N_CMP-2:0] & ~cmp_i[N_CMP-1:1]);

    assert_single_zero_R3: assert property (@(posedge clk) disable iff (rst)
        therm_ok |-> ($countones(~bus_n) == 1 && hi_hit));

    assert_code_is_zero_count_R2: assert property (@(posedge clk) disable iff (rst)
        therm_ok |=> (code_o == CODE_W'(N_CMP - $countones($past(cmp_i)))));

    assert_bottom_code_R4: assert property (@(posedge clk) disable iff (rst)
        (&cmp_i) |=> (code_o == '0));

    assert_top_code_R5: assert property (@(posedge clk) disable iff (rst)
        (~|cmp_i) |=> (code_o == '1));
endmodule

// File: tb/flash_therm_encoder_tb.sv
module flash_therm_encoder_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [254:0] cmp_i = '1;
    logic [7:0]   code_o;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    flash_therm_encoder u_dut (
        .clk    (clk),
        .rst    (rst),
        .cmp_i  (cmp_i),
        .code_o (code_o)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [8:0] zeros;
        logic [7:0] expect_code;
    } edge_vec_t;

    // R6 slice boundaries, plus R4/R5 ends
    localparam edge_vec_t EDGE_TBL [12] = '{
        '{9'd0,   8'h00}, '{9'd255, 8'hFF}, '{9'd15,  8'h0F}, '{9'd16,  8'h10},
        '{9'd17,  8'h11}, '{9'd31,  8'h1F}, '{9'd32,  8'h20}, '{9'd128, 8'h80},
        '{9'd239, 8'hEF}, '{9'd240, 8'hF0}, '{9'd254, 8'hFE}, '{9'd1,   8'h01}
    };

    function automatic logic [254:0] therm(input int k);
        logic [254:0] v;
        v = '1;
        for (int i = 0; i < 255; i++) if (i < k) v[i] = 1'b0;
        return v;
    endfunction

    task automatic check(input logic [7:0] exp_v, input string req);
        checks++;
        if (code_o !== exp_v) begin
            fails++;
            $display("FAIL %s: code_o=%0h expected=%0h", req, code_o, exp_v);
        end
    endtask

    // Drive at a falling edge, capture at the rising edge, check at the next falling edge
    task automatic apply(input logic [254:0] v, input logic [7:0] exp_v, input string req);
        @(negedge clk);
        cmp_i = v;
        @(negedge clk);
        check(exp_v, req);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: code_o=%0h expected=completion", code_o);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cmp_i = '0;
        repeat (2) @(negedge clk);
        check(8'h00, "R1 reset state");
        @(negedge clk);
        rst = 1'b0;

        // R3/R4/R5/R6 table
        for (int t = 0; t < 12; t++) begin
            apply(therm(int'(EDGE_TBL[t].zeros)), EDGE_TBL[t].expect_code, "R6 table");
        end

        // R3 sweep of all legal thermometer words
        for (int k = 0; k < 256; k++) begin
            apply(therm(k), 8'(k), "R3 sweep");
        end

        // R4 and R5 ends
        apply('1, 8'h00, "R4 all ones");
        apply('0, 8'hFF, "R5 all zeros");

        // R7 bubble: five zeros at the bottom with bit 2 forced to 1 -> zeros at positions 2 and 5
        begin
            logic [254:0] b;
            b = therm(5);
            b[2] = 1'b1;
            apply(b, 8'h07, "R7 bubble");
        end

        // R2 latency: the output still holds the old code before the capturing edge
        apply(therm(100), 8'd100, "R2 setup");
        @(negedge clk);
        cmp_i = therm(200);
        #2;
        check(8'd100, "R2 before edge");
        @(negedge clk);
        check(8'd200, "R2 after edge");

        // R1 reset wins over a full-scale input
        @(negedge clk);
        cmp_i = '0;
        rst = 1'b1;
        @(negedge clk);
        check(8'h00, "R1 reset over input");
        rst = 1'b0;
        @(negedge clk);
        check(8'hFF, "R1 release");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule